// File: doc/BRIEF.md
# Word-Addressed Serial Port Controller

This block is a memory-mapped asynchronous serial port. Software configures it and moves characters through a bank of 32-bit registers on a simple single-cycle slave port. A read returns data in the same cycle, and any side effect of that read takes place at the next clock edge. Each character is 8 bits wide. The block wraps it in a start bit, an optional parity bit and one stop bit, and sends it on a line that idles high. A 16-entry FIFO sits on each side. An internal rate generator produces a tick at 16 times the bit rate. It has two ways of counting, and a single run bit in the control register stops it. Software can therefore change the rate value without touching the frame settings.

The receiver double-registers the incoming line and finds the middle of each bit by counting 16 ticks. It records parity and stop-bit faults in sticky status flags. Software empties either FIFO by writing to a dedicated register. The guard-time, timeout and interrupt-enable registers are plain storage and drive no logic here.

Top module: `sercom_ctrl`

## Requirements
- R1: Register word indexes are taken from address bits [5:2]: 0 rate value (16 bits), 1 send data, 2 receive data, 3 control, 4 interrupt enable (16 bits), 5 status, 6 guard time (16 bits), 7 timeout (16 bits), 8 send flush, 9 receive flush. An access takes effect only when bits [1:0] and every bit above [5] are zero. All storage resets to zero, and indexes 10 to 15 read as zero.
- R2: The control register keeps only bits [5:0], 7, 8 and 12, so it reads back masked with 0x11BF. The mode field is bits [2:0]. Mode 7 adds a parity bit and any other value sends 8 data bits with no parity. Bit 5 set selects odd parity and clear selects even. The stop field in bits [4:3] is stored only.
- R3: With control bit 12 clear, the tick fires once every N clock cycles, where N is the rate value and 0 counts as 1. With bit 12 set, the rate value is added to a 16-bit accumulator every cycle and the carry out is the tick. One bit lasts 16 ticks.
- R4: A transmitted frame is a low start bit, 8 data bits LSB first, the parity bit when enabled, and a high stop bit. The line is high whenever no frame is in progress.
- R5: The send FIFO holds 16 characters. Status bit 9 is set while it is full, and a write to send data while it is full is dropped.
- R6: With control bit 7 (run) clear, no ticks are produced and no new frame is started.
- R7: Writing a value with bit 0 set to the send flush register empties the send FIFO. Status bit 1 is set when the send FIFO is empty and the transmitter is idle.
- R8: The receiver works only while run and control bit 8 are both set. It samples each bit at the middle of its 16 ticks and drops a start bit that is high at its middle.
- R9: Status bit 0 is set while received data is waiting. A read of receive data returns the oldest character. A read of receive data while the FIFO is empty returns zero and changes nothing.
- R10: A parity mismatch sets status bit 2 and a stop bit sampled low sets status bit 3. The character is stored in either case. A read of the status register clears both flags.
- R11: Writing a value with bit 0 set to the receive flush register empties the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ser_txd | output | 1 | Serial output line |
| ser_rxd | input | 1 | Serial input line |

## Verification
The bench uses the default parameters: 16-entry FIFOs and a 16-bit rate value. At these sizes the send FIFO can be filled to its full flag in a few cycles, and the 17th write can be shown to be dropped. With a rate value of 1 in counting mode, one bit takes 16 clocks, so frames finish quickly. Rate values of 2 in counting mode and 0x8000 in accumulating mode both give 32-clock bits, which exercises each tick path. The receiver tests drive corrupted parity, a low stop bit and a three-cycle glitch on the input line.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
   localparam int IDX_W = 4;

   typedef enum logic [IDX_W-1:0] {
      IDX_RATE   = 4'd0,
      IDX_TXDATA = 4'd1,
      IDX_RXDATA = 4'd2,
      IDX_CTRL   = 4'd3,
      IDX_INTEN  = 4'd4,
      IDX_STATUS = 4'd5,
      IDX_GUARD  = 4'd6,
      IDX_TMO    = 4'd7,
      IDX_TXRST  = 4'd8,
      IDX_RXRST  = 4'd9
   } reg_idx_e;

   localparam int CTL_ODD   = 5;
   localparam int CTL_RUN   = 7;
   localparam int CTL_RXEN  = 8;
   localparam int CTL_BMODE = 12;
   localparam logic [31:0] CTL_MASK = 32'h0000_11BF;
   localparam logic [2:0]  MODE_PAR = 3'd7;

   localparam int ST_RXAV   = 0;
   localparam int ST_TXIDLE = 1;
   localparam int ST_PERR   = 2;
   localparam int ST_FERR   = 3;
   localparam int ST_TXFULL = 9;
endpackage

// File: rtl/sercom_fifo.sv
module sercom_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH):0]     count
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("sercom_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= din;
   end
endmodule

// File: rtl/sercom_baud.sv
module sercom_baud #(
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          acc_mode,
   input  logic [RW-1:0] rate,
   output logic          tick
);
   if (RW < 2) begin : g_bad_rw
      $error("sercom_baud: RW must be at least 2");
   end

   logic [RW-1:0] cnt;
   logic [RW:0]   sum;

   assign sum = {1'b0, cnt} + {1'b0, rate};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (acc_mode) begin
         cnt  <= sum[RW-1:0];
         tick <= sum[RW];
      end else if (cnt == '0) begin
         tick <= 1'b1;
         cnt  <= (rate == '0) ? '0 : rate - 1'b1;
      end else begin
         tick <= 1'b0;
         cnt  <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx #(
   parameter int W   = 8,
   parameter int OVS = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic         par_en,
   input  logic         par_odd,
   input  logic         avail,
   input  logic [W-1:0] data,
   output logic         pop,
   output logic         txd,
   output logic         busy
);
   localparam int FW  = W + 3;
   localparam int PHW = $clog2(OVS);
   localparam int BCW = $clog2(FW + 1);

   if (OVS < 4 || (1 << PHW) != OVS) begin : g_bad_ovs
      $error("sercom_tx: OVS must be a power of two of at least 4");
   end

   logic [FW-1:0]  sh;
   logic [PHW-1:0] phase;
   logic [BCW-1:0] left;
   logic           par;

   assign pop = run && !busy && avail;
   assign par = par_odd ? ~^data : ^data;
   assign txd = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sh    <= '1;
         phase <= '0;
         left  <= '0;
      end else if (pop) begin
         busy  <= 1'b1;
         sh    <= par_en ? {1'b1, par, data, 1'b0} : {2'b11, data, 1'b0};
         left  <= par_en ? BCW'(FW) : BCW'(FW - 1);
         phase <= '0;
      end else if (busy && tick) begin
         if (phase == PHW'(OVS - 1)) begin
            phase <= '0;
            sh    <= {1'b1, sh[FW-1:1]};
            left  <= left - 1'b1;
            if (left == BCW'(1)) busy <= 1'b0;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx #(
   parameter int W   = 8,
   parameter int OVS = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic         par_en,
   input  logic         par_odd,
   input  logic         rxd,
   output logic         push,
   output logic [W-1:0] data,
   output logic         perr,
   output logic         ferr
);
   localparam int PHW = $clog2(OVS);
   localparam int IXW = $clog2(W + 3);
   localparam logic [PHW-1:0] MID = PHW'(OVS / 2 - 1);

   if (OVS < 4 || (1 << PHW) != OVS) begin : g_bad_ovs
      $error("sercom_rx: OVS must be a power of two of at least 4");
   end

   logic           s1, s2, active, parv;
   logic [PHW-1:0] phase;
   logic [IXW-1:0] idx, last;
   logic           exp_par;

   assign last    = par_en ? IXW'(W + 2) : IXW'(W + 1);
   assign exp_par = par_odd ? ~^data : ^data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
      end else begin
         s1 <= rxd;
         s2 <= s1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= '0;
         idx    <= '0;
         data   <= '0;
         parv   <= 1'b0;
         push   <= 1'b0;
         perr   <= 1'b0;
         ferr   <= 1'b0;
      end else begin
         push <= 1'b0;
         perr <= 1'b0;
         ferr <= 1'b0;
         if (!en) begin
            active <= 1'b0;
         end else if (tick) begin
            if (!active) begin
               if (!s2) begin
                  active <= 1'b1;
                  phase  <= '0;
                  idx    <= '0;
               end
            end else begin
               phase <= phase + 1'b1;
               if (phase == PHW'(OVS - 1)) idx <= idx + 1'b1;
               if (phase == MID) begin
                  if (idx == '0) begin
                     if (s2) active <= 1'b0;
                  end else if (idx == last) begin
                     active <= 1'b0;
                     push   <= 1'b1;
                     ferr   <= !s2;
                     perr   <= par_en && (parv != exp_par);
                  end else if (idx <= IXW'(W)) begin
                     data <= {s2, data[W-1:1]};
                  end else begin
                     parv <= s2;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/sercom_ctrl.sv
module sercom_ctrl
   import sercom_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int RATE_W     = 16,
   parameter int AUX_W      = 16,
   parameter int ADDR_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              ser_txd,
   input  logic              ser_rxd
);
   localparam int DW  = 8;
   localparam int OVS = 16;
   localparam int CW  = $clog2(FIFO_DEPTH) + 1;

   if (ADDR_W < 6 || RATE_W > 32 || AUX_W > 32) begin : g_bad_cfg
      $error("sercom_ctrl: ADDR_W must be >= 6, RATE_W and AUX_W <= 32");
   end

   logic [IDX_W-1:0]  idx;
   logic              hit, wr, rd;
   logic [RATE_W-1:0] rate_q;
   logic [AUX_W-1:0]  inten_q, guard_q, tmo_q;
   logic [31:0]       ctrl_q, status_w;
   logic              perr_q, ferr_q, run, par_en;
   logic              tx_push, tx_pop, tx_clr, rx_pop, rx_clr, status_rd;
   logic              txf_empty, txf_full, rxf_empty, rxf_full;
   logic [CW-1:0]     txf_count, rxf_count;
   logic [DW-1:0]     txf_dout, rxf_dout, rx_data;
   logic              baud_tick, tx_busy, rx_push, rx_perr_p, rx_ferr_p;

   assign idx    = bus_addr[5:2];
   assign hit    = bus_req && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 6) == '0);
   assign wr     = hit && bus_we;
   assign rd     = hit && !bus_we;
   assign run    = ctrl_q[CTL_RUN];
   assign par_en = (ctrl_q[2:0] == MODE_PAR);

   assign tx_push   = wr && (idx == IDX_TXDATA);
   assign tx_clr    = wr && (idx == IDX_TXRST) && bus_wdata[0];
   assign rx_clr    = wr && (idx == IDX_RXRST) && bus_wdata[0];
   assign rx_pop    = rd && (idx == IDX_RXDATA);
   assign status_rd = rd && (idx == IDX_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q  <= '0;
         ctrl_q  <= '0;
         inten_q <= '0;
         guard_q <= '0;
         tmo_q   <= '0;
      end else if (wr) begin
         case (idx)
            IDX_RATE:  rate_q  <= bus_wdata[RATE_W-1:0];
            IDX_CTRL:  ctrl_q  <= bus_wdata & CTL_MASK;
            IDX_INTEN: inten_q <= bus_wdata[AUX_W-1:0];
            IDX_GUARD: guard_q <= bus_wdata[AUX_W-1:0];
            IDX_TMO:   tmo_q   <= bus_wdata[AUX_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perr_q <= 1'b0;
         ferr_q <= 1'b0;
      end else begin
         if (status_rd) begin
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
         end
         if (rx_perr_p) perr_q <= 1'b1;
         if (rx_ferr_p) ferr_q <= 1'b1;
      end
   end

   always_comb begin
      status_w            = '0;
      status_w[ST_RXAV]   = !rxf_empty;
      status_w[ST_TXIDLE] = txf_empty && !tx_busy;
      status_w[ST_PERR]   = perr_q;
      status_w[ST_FERR]   = ferr_q;
      status_w[ST_TXFULL] = txf_full;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         case (idx)
            IDX_RATE:   bus_rdata = 32'(rate_q);
            IDX_RXDATA: bus_rdata = rxf_empty ? '0 : 32'(rxf_dout);
            IDX_CTRL:   bus_rdata = ctrl_q;
            IDX_INTEN:  bus_rdata = 32'(inten_q);
            IDX_STATUS: bus_rdata = status_w;
            IDX_GUARD:  bus_rdata = 32'(guard_q);
            IDX_TMO:    bus_rdata = 32'(tmo_q);
            default:    bus_rdata = '0;
         endcase
      end
   end

   sercom_baud #(.RW(RATE_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(run), .acc_mode(ctrl_q[CTL_BMODE]),
      .rate(rate_q), .tick(baud_tick));

   sercom_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txf (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(bus_wdata[DW-1:0]),
      .pop(tx_pop), .dout(txf_dout), .empty(txf_empty), .full(txf_full), .count(txf_count));

   sercom_tx #(.W(DW), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(baud_tick), .par_en(par_en),
      .par_odd(ctrl_q[CTL_ODD]), .avail(!txf_empty), .data(txf_dout), .pop(tx_pop),
      .txd(ser_txd), .busy(tx_busy));

   sercom_rx #(.W(DW), .OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(run && ctrl_q[CTL_RXEN]), .tick(baud_tick),
      .par_en(par_en), .par_odd(ctrl_q[CTL_ODD]), .rxd(ser_rxd), .push(rx_push),
      .data(rx_data), .perr(rx_perr_p), .ferr(rx_ferr_p));

   sercom_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxf (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(rx_data),
      .pop(rx_pop), .dout(rxf_dout), .empty(rxf_empty), .full(rxf_full), .count(rxf_count));
endmodule

// File: rtl/sercom_ctrl_chk.sv
module sercom_ctrl_chk #(
   parameter int CW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          baud_tick,
   input logic          tx_busy,
   input logic          tx_push,
   input logic          tx_pop,
   input logic          tx_clr,
   input logic          rx_clr,
   input logic          rx_pop,
   input logic          status_rd,
   input logic          txf_full,
   input logic          txf_empty,
   input logic          rxf_empty,
   input logic          rxf_full,
   input logic [CW-1:0] txf_count,
   input logic [CW-1:0] rxf_count,
   input logic          rx_perr_p,
   input logic          rx_ferr_p,
   input logic          perr_q,
   input logic          ferr_q,
   input logic [31:0]   bus_rdata
);
   // R7
   tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |=> (txf_empty && txf_count == '0));

   // R11
   rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr |=> (rxf_empty && rxf_count == '0));

   // R5
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && txf_full && !tx_pop && !tx_clr) |=> (txf_full && $stable(txf_count)));

   // R9
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && rxf_empty) |-> (bus_rdata == 32'd0));

   // R9
   empty_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && rxf_empty && !rx_clr) |=> !rxf_full);

   // R10
   sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !rx_perr_p && !rx_ferr_p) |=> (!perr_q && !ferr_q));

   // R6
   halt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !baud_tick);

   // R6
   halt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !tx_busy) |=> !tx_busy);
endmodule

bind sercom_ctrl sercom_ctrl_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .baud_tick(baud_tick), .tx_busy(tx_busy),
   .tx_push(tx_push), .tx_pop(tx_pop), .tx_clr(tx_clr), .rx_clr(rx_clr), .rx_pop(rx_pop),
   .status_rd(status_rd), .txf_full(txf_full), .txf_empty(txf_empty), .rxf_empty(rxf_empty),
   .rxf_full(rxf_full), .txf_count(txf_count), .rxf_count(rxf_count), .rx_perr_p(rx_perr_p),
   .rx_ferr_p(rx_ferr_p), .perr_q(perr_q), .ferr_q(ferr_q), .bus_rdata(bus_rdata));

// File: tb/sercom_ctrl_test.sv
module sercom_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0, bus_req = 1'b0, bus_we = 1'b0, ser_rxd = 1'b1;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ser_txd;

   int checks = 0, errors = 0, frames = 0, bit_cyc = 16;
   bit par_en = 1'b0, par_odd = 1'b0;
   logic [7:0] exp_q[$];
   logic [7:0] md;
   logic [31:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   sercom_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_txd(ser_txd), .ser_rxd(ser_rxd));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(int idx, logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'(idx * 4); bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(int idx, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = 6'(idx * 4);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_req = 1'b0;
   endtask

   task automatic rd_chk(string tag, int idx, logic [31:0] exp);
      logic [31:0] d;
      rd(idx, d);
      check(tag, d, exp);
   endtask

   task automatic send(logic [7:0] d);
      exp_q.push_back(d);
      wr(1, {24'd0, d});
   endtask

   task automatic wait_frames(int n);
      for (int i = 0; i < 40000 && frames < n; i++) @(negedge clk);
   endtask

   task automatic drive_rx(logic [7:0] d, bit wp, bit pv, bit sv);
      @(negedge clk); ser_rxd = 1'b0;
      repeat (bit_cyc) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_rxd = d[i];
         repeat (bit_cyc) @(negedge clk);
      end
      if (wp) begin
         ser_rxd = pv;
         repeat (bit_cyc) @(negedge clk);
      end
      ser_rxd = sv;
      repeat (bit_cyc) @(negedge clk);
      ser_rxd = 1'b1;
      repeat (bit_cyc) @(negedge clk);
   endtask

   // scoreboard monitor: decodes frames on ser_txd and compares with the queue (R4)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ser_txd === 1'b0) begin
            repeat (bit_cyc / 2) @(negedge clk);
            check("R4 start bit", 32'(ser_txd), 32'd0);
            for (int i = 0; i < 8; i++) begin
               repeat (bit_cyc) @(negedge clk);
               md[i] = ser_txd;
            end
            if (par_en) begin
               repeat (bit_cyc) @(negedge clk);
               check("R4 parity bit", 32'(ser_txd), 32'(par_odd ? ~^md : ^md));
            end
            repeat (bit_cyc) @(negedge clk);
            check("R4 stop bit", 32'(ser_txd), 32'd1);
            frames++;
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R5 unexpected frame: actual=%h expected=none", md);
            end else begin
               check("R4 data", 32'(md), 32'(exp_q.pop_front()));
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int base;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R4 idle line after reset", 32'(ser_txd), 32'd1);
      rd_chk("R1 rate reset", 0, 32'd0);
      rd_chk("R1 control reset", 3, 32'd0);
      rd_chk("R7 status reset", 5, 32'h2);
      rd_chk("R9 empty receive read", 2, 32'd0);
      // R1 storage registers
      wr(0, 32'hFFFF_0001); wr(6, 32'h0000_ABCD); wr(7, 32'h0000_1234); wr(4, 32'h0000_05A5);
      rd_chk("R1 rate readback", 0, 32'h1);
      rd_chk("R1 guard readback", 6, 32'hABCD);
      rd_chk("R1 timeout readback", 7, 32'h1234);
      rd_chk("R1 inten readback", 4, 32'h05A5);
      rd_chk("R1 unused index", 12, 32'd0);
      wr(3, 32'hFFFF_FFFF);
      rd_chk("R2 control mask", 3, 32'h11BF);
      wr(3, 32'h0);

      // R5 fill with run clear, R6 no transmission
      for (int i = 0; i < 16; i++) send(8'(i * 17 + 3));
      rd_chk("R5 full flag", 5, 32'h200);
      wr(1, 32'hEE);
      repeat (200) @(negedge clk);
      check("R6 line idle while stopped", 32'(ser_txd), 32'd1);
      base = frames;
      wr(3, 32'h89);
      wait_frames(base + 16);
      repeat (40 * bit_cyc) @(negedge clk);
      check("R5 dropped write not sent", 32'(frames - base), 32'd16);
      rd_chk("R7 idle after drain", 5, 32'h2);

      // R7 flush
      wr(3, 32'h0);
      wr(1, 32'h11); wr(1, 32'h22); wr(1, 32'h33);
      rd_chk("R7 not idle with data", 5, 32'h0);
      wr(8, 32'h1);
      rd_chk("R7 idle after flush", 5, 32'h2);
      base = frames;
      wr(3, 32'h89);
      repeat (30 * bit_cyc) @(negedge clk);
      check("R7 flushed data not sent", 32'(frames - base), 32'd0);

      // R2 parity modes
      par_en = 1'b1; par_odd = 1'b1;
      wr(3, 32'hAF);
      base = frames;
      send(8'h00); send(8'h01);
      wait_frames(base + 2);
      wr(3, 32'h0); par_odd = 1'b0;
      wr(3, 32'h8F);
      send(8'h03);
      wait_frames(base + 3);
      repeat (2 * bit_cyc) @(negedge clk);
      par_en = 1'b0;

      // R3 rate paths
      wr(3, 32'h0); wr(0, 32'h2); bit_cyc = 32;
      wr(3, 32'h89);
      base = frames;
      send(8'h5A);
      wait_frames(base + 1);
      repeat (2 * bit_cyc) @(negedge clk);
      wr(3, 32'h0); wr(0, 32'h8000);
      wr(3, 32'h1089);
      send(8'hC3);
      wait_frames(base + 2);
      repeat (2 * bit_cyc) @(negedge clk);
      check("R3 frames at both rates", 32'(frames - base), 32'd2);
      wr(3, 32'h0); wr(0, 32'h1); bit_cyc = 16;

      // R8, R9 reception
      wr(3, 32'h189);
      drive_rx(8'h3C, 0, 0, 1);
      drive_rx(8'hA5, 0, 0, 1);
      rd_chk("R9 data waiting", 5, 32'h3);
      rd_chk("R9 oldest first", 2, 32'h3C);
      rd_chk("R9 second char", 2, 32'hA5);
      rd_chk("R9 empty read zero", 2, 32'h0);
      rd_chk("R9 empty read no change", 5, 32'h2);

      // R10 parity fault
      wr(3, 32'h1AF);
      drive_rx(8'h5A, 1, 1, 1);
      rd_chk("R10 good parity", 5, 32'h3);
      rd_chk("R10 good parity data", 2, 32'h5A);
      drive_rx(8'h5A, 1, 0, 1);
      rd_chk("R10 parity flag", 5, 32'h7);
      rd_chk("R10 flag cleared by read", 5, 32'h3);
      rd_chk("R10 char kept", 2, 32'h5A);

      // R10 framing fault
      wr(3, 32'h189);
      drive_rx(8'h77, 0, 0, 0);
      repeat (12 * bit_cyc) @(negedge clk);
      rd(5, rv);
      check("R10 framing flag", rv & 32'h9, 32'h9);
      // R11 receive flush
      wr(9, 32'h1);
      rd_chk("R11 empty after flush", 5, 32'h2);

      // R8 glitch and disabled receiver
      @(negedge clk); ser_rxd = 1'b0;
      repeat (3) @(negedge clk); ser_rxd = 1'b1;
      repeat (20 * bit_cyc) @(negedge clk);
      rd_chk("R8 glitch discarded", 5, 32'h2);
      wr(3, 32'h89);
      drive_rx(8'h11, 0, 0, 1);
      rd_chk("R8 receiver disabled", 5, 32'h2);
      wr(3, 32'h189);
      drive_rx(8'h22, 0, 0, 1);
      rd_chk("R11 data before flush", 5, 32'h3);
      wr(9, 32'h1);
      rd_chk("R11 flush clears data", 5, 32'h2);
      rd_chk("R11 flushed read zero", 2, 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule